// File: doc/BRIEF.md
# Complementary PWM Break Shutdown Controller

This block sits between a PWM generator and a bank of complementary output pairs. Its job is to force those outputs into a safe state when a fault appears. Two independent break channels each combine one external fault pin with several internal fault sources, and each channel also accepts a one-shot software trigger.

A master output-enable flag lets the raw PWM legs through. Software sets this flag, and any enabled break clears it at once, without waiting for a clock edge. While the flag is low, every pair either drives programmed shutdown levels or releases its pins to high impedance. No pair is ever allowed to have both legs active together.

Software reaches the block through a flat register port with write strobe, address and write data. Reads are combinational on the same address. The read copy of the master flag passes through a synchroniser, so it trails the flag that acts on the outputs.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, CTRL (address 0) and STAT (address 4) read 0, every `out_oe` bit is 0 and every `out_p`/`out_n` bit is 0.
- R2: CTRL bits 2/3 hold channel 0 enable and pin polarity, and bits 4/5 do the same for channel 1 (polarity 1 means the pin is active high). These bits start to gate faults one clock after the write. A read in the cycle right after the write returns the old value.
- R3: A channel's hardware fault is its effective enable ANDed with the OR of its pin and its masked internal sources. SRC0 (address 1) and SRC1 (address 2) hold the per-source enables in bits [NINT-1:0] and the per-source inversions in bits [2*NINT-1:NINT]. The inversion applies only to sources marked in `CMP_POL_MASK` (source 0 by default); for the other sources it is ignored.
- R4: Writing 1 to bit 0 or bit 1 of SWTRIG (address 5) raises a one-cycle break on channel 0 or channel 1. The trigger works whatever the channel enable says, and SWTRIG reads 0.
- R5: A break on either channel clears the master output enable. Writing CTRL with bit 0 = 1 sets the enable again, and writing bit 0 = 0 clears it.
- R6: A fault pulse that starts and ends between two clock edges drops the outputs into the shutdown state at once, and they stay there after the pulse ends.
- R7: CTRL bit 0 reads the master enable through a SYNC_STAGES-flop synchroniser. After a set, it reads 0 for SYNC_STAGES cycles even though the outputs are already enabled.
- R8: While disabled, CTRL bit 1 = 1 drives every pair with `out_oe` = 1. CTRL bit 1 = 0 releases every pair with `out_oe` = 0 and both legs at 0.
- R9: LVL (address 3) bit 2p is the shutdown level of `out_p[p]` and bit 2p+1 is that of `out_n[p]`. When both are 1, `out_n[p]` is forced to 0.
- R10: While enabled, `out_p` follows `pwm_p` and `out_n` follows `pwm_n` with `out_oe` = 1. The exception is that `out_n[p]` is 0 whenever `pwm_p[p]` is 1.
- R11: STAT bit c is set at the clock edge where channel c is in break. Writing 1 to the bit clears it, and a set in the same cycle wins over the clear.
- R12: A write that sets the master enable has no effect while any channel's break is still asserted.
- R13: A channel whose enable bit is 0 ignores its pin and its internal sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| brk_pin | input | 2 | External fault pin per channel |
| brk_int0 | input | NINT | Internal fault sources, channel 0 |
| brk_int1 | input | NINT | Internal fault sources, channel 1 |
| pwm_p | input | NPAIR | Raw primary PWM legs |
| pwm_n | input | NPAIR | Raw complementary PWM legs |
| out_p | output | NPAIR | Guarded primary legs |
| out_n | output | NPAIR | Guarded complementary legs |
| out_oe | output | NPAIR | Per-pair drive enable (0 = high impedance) |

## Verification
The bench goes after a fault pulse that lies entirely between two clock edges. A design that samples faults on the clock would miss that pulse and keep the outputs running.

It also covers the following corner cases:
- Simultaneous breaks on both channels followed by separate write-1 clears. A shared or mis-indexed sticky flag would clear the wrong channel.
- A set of the master enable while a fault is still held. A design without blocking would re-enable into the fault.
- A readback taken in the cycle right after enable and polarity writes, and another right after setting the master enable. These expose a missing or extra delay stage.
- A full sweep of shutdown levels and raw PWM codes. It catches any pair that lets both legs go active.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
package pfg_pkg;
   localparam int PFG_AW = 3;
   localparam int PFG_NCH = 2;

   typedef enum logic [PFG_AW-1:0] {
      A_CTRL = 3'd0,
      A_SRC0 = 3'd1,
      A_SRC1 = 3'd2,
      A_LVL  = 3'd3,
      A_STAT = 3'd4,
      A_SWT  = 3'd5
   } pfg_addr_e;

   localparam int C_MOE  = 0;
   localparam int C_IDLE = 1;

   function automatic int en_bit(input int ch);
      return 2 + 2 * ch;
   endfunction

   function automatic int pol_bit(input int ch);
      return 3 + 2 * ch;
   endfunction
endpackage

// File: rtl/pfg_brk_channel.sv
`timescale 1ns/1ps
module pfg_brk_channel #(
   parameter int          NINT         = 3,
   parameter int unsigned CMP_POL_MASK = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_w,
   input  logic            pol_w,
   input  logic            pin,
   input  logic [NINT-1:0] int_src,
   input  logic [NINT-1:0] src_en,
   input  logic [NINT-1:0] src_pol,
   input  logic            sw_pulse,
   output logic            en_eff,
   output logic            pol_eff,
   output logic            fault
);
   logic [NINT-1:0] norm;
   logic            pin_act;
   logic            hw_fault;

   // one-cycle apply delay of enable/polarity
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_eff  <= 1'b0;
         pol_eff <= 1'b0;
      end else begin
         en_eff  <= en_w;
         pol_eff <= pol_w;
      end
   end

   for (genvar s = 0; s < NINT; s++) begin : g_src
      if (((CMP_POL_MASK >> s) & 1) != 0) begin : g_inv
         assign norm[s] = int_src[s] ^ src_pol[s];
      end else begin : g_fix
         assign norm[s] = int_src[s];
      end
   end

   logic unused_pol;
   assign unused_pol = ^src_pol;

   assign pin_act  = pol_eff ? pin : ~pin;
   assign hw_fault = en_eff & (pin_act | (|(norm & src_en)));
   assign fault    = hw_fault | sw_pulse;
endmodule

// File: rtl/pfg_moe_ctrl.sv
`timescale 1ns/1ps
module pfg_moe_ctrl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic set_req,
   input  logic clr_req,
   output logic moe_act,
   output logic moe_rd
);
   logic arst;
   logic moe_q;
   logic [SYNC_STAGES-1:0] sync_q;

   assign arst = ~rst_n | kill;

   // fault clears the flag without a clock; held low while fault persists
   always_ff @(posedge clk or posedge arst) begin
      if (arst)         moe_q <= 1'b0;
      else if (set_req) moe_q <= 1'b1;
      else if (clr_req) moe_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], moe_q};
   end

   assign moe_act = moe_q;
   assign moe_rd  = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/pfg_pair_gate.sv
`timescale 1ns/1ps
module pfg_pair_gate (
   input  logic moe,
   input  logic idle_drive,
   input  logic pwm_p,
   input  logic pwm_n,
   input  logic lvl_p,
   input  logic lvl_n,
   output logic out_p,
   output logic out_n,
   output logic oe
);
   logic raw_p;
   logic raw_n;

   always_comb begin
      if (moe) begin
         raw_p = pwm_p;
         raw_n = pwm_n;
      end else if (idle_drive) begin
         raw_p = lvl_p;
         raw_n = lvl_n;
      end else begin
         raw_p = 1'b0;
         raw_n = 1'b0;
      end
   end

   assign out_p = raw_p;
   assign out_n = raw_n & ~raw_p;
   assign oe    = moe | idle_drive;
endmodule

// File: rtl/pwm_fault_guard.sv
`timescale 1ns/1ps
module pwm_fault_guard
   import pfg_pkg::*;
#(
   parameter int          NPAIR        = 4,
   parameter int          NINT         = 3,
   parameter int          DW           = 16,
   parameter int          SYNC_STAGES  = 2,
   parameter int unsigned CMP_POL_MASK = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [PFG_AW-1:0]   reg_addr,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   input  logic [PFG_NCH-1:0]  brk_pin,
   input  logic [NINT-1:0]     brk_int0,
   input  logic [NINT-1:0]     brk_int1,
   input  logic [NPAIR-1:0]    pwm_p,
   input  logic [NPAIR-1:0]    pwm_n,
   output logic [NPAIR-1:0]    out_p,
   output logic [NPAIR-1:0]    out_n,
   output logic [NPAIR-1:0]    out_oe
);
   localparam int LVL_W = 2 * NPAIR;
   localparam int SRC_W = 2 * NINT;
   localparam int CTRL_W = 2 + 2 * PFG_NCH;

   if (NPAIR < 1 || NPAIR > 16) begin : g_bad_npair
      $error("NPAIR out of range");
   end
   if (NINT < 1 || NINT > 8) begin : g_bad_nint
      $error("NINT out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DW < LVL_W || DW < SRC_W || DW < CTRL_W) begin : g_bad_dw
      $error("DW too narrow for register fields");
   end

   logic                          idle_q;
   logic [PFG_NCH-1:0]            en_w, pol_w, en_eff, pol_eff;
   logic [PFG_NCH-1:0][NINT-1:0]  src_en_q, src_pol_q, int_v;
   logic [LVL_W-1:0]              lvl_q;
   logic [PFG_NCH-1:0]            sticky_q, sw_pulse_q, fault;
   logic                          moe_act, moe_rd;
   logic wr_ctrl, wr_src0, wr_src1, wr_lvl, wr_stat, wr_swt;

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign wr_src0 = reg_wr && (reg_addr == A_SRC0);
   assign wr_src1 = reg_wr && (reg_addr == A_SRC1);
   assign wr_lvl  = reg_wr && (reg_addr == A_LVL);
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign wr_swt  = reg_wr && (reg_addr == A_SWT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q     <= 1'b0;
         en_w       <= '0;
         pol_w      <= '0;
         src_en_q   <= '0;
         src_pol_q  <= '0;
         lvl_q      <= '0;
         sw_pulse_q <= '0;
      end else begin
         if (wr_ctrl) begin
            idle_q <= reg_wdata[C_IDLE];
            for (int c = 0; c < PFG_NCH; c++) begin
               en_w[c]  <= reg_wdata[en_bit(c)];
               pol_w[c] <= reg_wdata[pol_bit(c)];
            end
         end
         if (wr_src0) begin
            src_en_q[0]  <= reg_wdata[NINT-1:0];
            src_pol_q[0] <= reg_wdata[SRC_W-1:NINT];
         end
         if (wr_src1) begin
            src_en_q[1]  <= reg_wdata[NINT-1:0];
            src_pol_q[1] <= reg_wdata[SRC_W-1:NINT];
         end
         if (wr_lvl) lvl_q <= reg_wdata[LVL_W-1:0];
         sw_pulse_q <= wr_swt ? reg_wdata[PFG_NCH-1:0] : '0;
      end
   end

   // sticky break flags, set has priority over write-1-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
      end else begin
         for (int c = 0; c < PFG_NCH; c++) begin
            if (fault[c])                      sticky_q[c] <= 1'b1;
            else if (wr_stat && reg_wdata[c])  sticky_q[c] <= 1'b0;
         end
      end
   end

   assign int_v[0] = brk_int0;
   assign int_v[1] = brk_int1;

   for (genvar c = 0; c < PFG_NCH; c++) begin : g_ch
      pfg_brk_channel #(
         .NINT         (NINT),
         .CMP_POL_MASK (CMP_POL_MASK)
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .en_w     (en_w[c]),
         .pol_w    (pol_w[c]),
         .pin      (brk_pin[c]),
         .int_src  (int_v[c]),
         .src_en   (src_en_q[c]),
         .src_pol  (src_pol_q[c]),
         .sw_pulse (sw_pulse_q[c]),
         .en_eff   (en_eff[c]),
         .pol_eff  (pol_eff[c]),
         .fault    (fault[c])
      );
   end

   pfg_moe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_moe (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (|fault),
      .set_req (wr_ctrl &  reg_wdata[C_MOE]),
      .clr_req (wr_ctrl & ~reg_wdata[C_MOE]),
      .moe_act (moe_act),
      .moe_rd  (moe_rd)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pfg_pair_gate u_gate (
         .moe        (moe_act),
         .idle_drive (idle_q),
         .pwm_p      (pwm_p[p]),
         .pwm_n      (pwm_n[p]),
         .lvl_p      (lvl_q[2*p]),
         .lvl_n      (lvl_q[2*p+1]),
         .out_p      (out_p[p]),
         .out_n      (out_n[p]),
         .oe         (out_oe[p])
      );
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[C_MOE]  = moe_rd;
            reg_rdata[C_IDLE] = idle_q;
            for (int c = 0; c < PFG_NCH; c++) begin
               reg_rdata[en_bit(c)]  = en_eff[c];
               reg_rdata[pol_bit(c)] = pol_eff[c];
            end
         end
         A_SRC0: reg_rdata[SRC_W-1:0] = {src_pol_q[0], src_en_q[0]};
         A_SRC1: reg_rdata[SRC_W-1:0] = {src_pol_q[1], src_en_q[1]};
         A_LVL:  reg_rdata[LVL_W-1:0] = lvl_q;
         A_STAT: reg_rdata[PFG_NCH-1:0] = sticky_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pfg_checker.sv
`timescale 1ns/1ps
module pfg_checker #(
   parameter int NPAIR = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             moe_act,
   input logic             idle_q,
   input logic [1:0]       fault,
   input logic [1:0]       sticky_q,
   input logic [1:0]       en_w,
   input logic [1:0]       en_eff,
   input logic [1:0]       pol_w,
   input logic [1:0]       pol_eff,
   input logic [NPAIR-1:0] out_p,
   input logic [NPAIR-1:0] out_n,
   input logic [NPAIR-1:0] out_oe
);
   AST_NO_BOTH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) (out_p & out_n) == '0); // R9
   AST_FAULT_BLOCKS_MOE: assert property (@(posedge clk) disable iff (!rst_n) (|fault) |-> !moe_act); // R12
   AST_FAULT_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (|fault) |=> !moe_act); // R5
   AST_EN_LAG: assert property (@(posedge clk) disable iff (!rst_n) en_eff == $past(en_w)); // R2
   AST_POL_LAG: assert property (@(posedge clk) disable iff (!rst_n) pol_eff == $past(pol_w)); // R2
   AST_STICKY0_SET: assert property (@(posedge clk) disable iff (!rst_n) fault[0] |=> sticky_q[0]); // R11
   AST_STICKY1_SET: assert property (@(posedge clk) disable iff (!rst_n) fault[1] |=> sticky_q[1]); // R11
   AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (!moe_act && !idle_q) |-> out_oe == '0); // R8
   AST_IDLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (!moe_act && idle_q) |-> &out_oe); // R8
endmodule

bind pwm_fault_guard pfg_checker #(.NPAIR(NPAIR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .moe_act  (moe_act),
   .idle_q   (idle_q),
   .fault    (fault),
   .sticky_q (sticky_q),
   .en_w     (en_w),
   .en_eff   (en_eff),
   .pol_w    (pol_w),
   .pol_eff  (pol_eff),
   .out_p    (out_p),
   .out_n    (out_n),
   .out_oe   (out_oe)
);

// File: tb/sim_pwm_fault_guard.sv
`timescale 1ns/100ps
module sim_pwm_fault_guard;
   localparam int NPAIR = 4;
   localparam int NINT = 3;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [1:0] brk_pin = '0;
   logic [NINT-1:0] brk_int0 = '0, brk_int1 = '0;
   logic [NPAIR-1:0] pwm_p = '0, pwm_n = '0;
   logic [NPAIR-1:0] out_p, out_n, out_oe;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   pwm_fault_guard u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_pin(brk_pin),
      .brk_int0(brk_int0), .brk_int1(brk_int1), .pwm_p(pwm_p), .pwm_n(pwm_n),
      .out_p(out_p), .out_n(out_n), .out_oe(out_oe)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // write; returns at the falling edge after the capturing rising edge
   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #0.1;
      d = reg_rdata;
   endtask

   function automatic logic [DW-1:0] ctrl(input bit moe, input bit idle,
         input bit e0, input bit p0, input bit e1, input bit p1);
      return DW'({p1, e1, p0, e0, idle, moe});
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] r;
      logic [NPAIR-1:0] ep, en;
      tick(4);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(3'd0, r); chk("R1 ctrl", r, 0);
      rd(3'd4, r); chk("R1 stat", r, 0);
      chk("R1 oe", out_oe, 0);
      chk("R1 out_p", out_p, 0);
      chk("R1 out_n", out_n, 0);

      // R9 shutdown level sweep while driven
      wr(3'd0, ctrl(0, 1, 0, 0, 0, 0));
      for (int v = 0; v < 256; v++) begin
         wr(3'd3, DW'(v));
         for (int p = 0; p < NPAIR; p++) begin
            ep[p] = v[2*p];
            en[p] = v[2*p+1] & ~v[2*p];
         end
         chk("R9 lvl out_p", out_p, ep);
         chk("R9 lvl out_n", out_n, en);
         chk("R8 drive oe", out_oe, 4'hF);
      end

      // R8 release
      wr(3'd0, ctrl(0, 0, 0, 0, 0, 0));
      chk("R8 release oe", out_oe, 0);
      chk("R8 release out_p", out_p, 0);
      chk("R8 release out_n", out_n, 0);

      // R10 passthrough sweep
      wr(3'd0, ctrl(1, 1, 0, 0, 0, 0));
      for (int v = 0; v < 256; v++) begin
         pwm_p = v[3:0]; pwm_n = v[7:4];
         #0.5;
         chk("R10 out_p", out_p, v[3:0]);
         chk("R10 out_n", out_n, v[7:4] & ~v[3:0]);
         chk("R10 oe", out_oe, 4'hF);
      end

      // R7 readback lag of master enable
      wr(3'd3, 0);
      pwm_p = 4'hF; pwm_n = 4'h0;
      wr(3'd0, ctrl(0, 1, 0, 0, 0, 0));
      tick(3);
      chk("R5 sw clear", out_p, 0);
      wr(3'd0, ctrl(1, 1, 0, 0, 0, 0));
      chk("R7 outputs live at once", out_p, 4'hF);
      rd(3'd0, r); chk("R7 rd lag 1", r[0], 0);
      tick(1); rd(3'd0, r); chk("R7 rd lag 2", r[0], 0);
      tick(1); rd(3'd0, r); chk("R7 rd settled", r[0], 1);

      // R2 enable/polarity one-cycle apply
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      rd(3'd0, r); chk("R2 old value", r[5:2], 4'h0);
      tick(1); rd(3'd0, r); chk("R2 new value", r[5:2], 4'hF);
      chk("R2 no fault pins low", out_p, 4'hF);

      // R2 polarity flip gating delay: ch0 active-low pin at 0 becomes fault
      wr(3'd0, ctrl(1, 1, 1, 0, 1, 1));
      chk("R2 pol not yet applied", out_p, 4'hF);
      tick(1);
      chk("R2 pol applied", out_p, 0);
      wr(3'd0, ctrl(0, 1, 1, 1, 1, 1));
      tick(1);
      wr(3'd4, 2'b11);
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      chk("R5 restore", out_p, 4'hF);

      // R6 mid-cycle pulse
      @(negedge clk); #0.5 brk_pin[0] = 1'b1;
      #0.5 chk("R6 immediate off", out_p, 0);
      chk("R6 drive oe", out_oe, 4'hF);
      #0.5 brk_pin[0] = 1'b0;
      tick(1);
      chk("R6 stays off", out_p, 0);
      tick(2);
      rd(3'd0, r); chk("R5 rd cleared", r[0], 0);
      wr(3'd4, 2'b11);
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      chk("R5 restore 2", out_p, 4'hF);

      // R11 simultaneous faults, separate clears
      @(negedge clk); brk_pin = 2'b11;
      #0.5 chk("R5 both off", out_p, 0);
      tick(1); brk_pin = 2'b00;
      rd(3'd4, r); chk("R11 both sticky", r[1:0], 2'b11);
      wr(3'd4, 2'b01);
      rd(3'd4, r); chk("R11 clear ch0", r[1:0], 2'b10);
      wr(3'd4, 2'b10);
      rd(3'd4, r); chk("R11 clear ch1", r[1:0], 2'b00);

      // R12 set blocked while fault held
      brk_pin[1] = 1'b1;
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      tick(3);
      chk("R12 blocked out", out_p, 0);
      rd(3'd0, r); chk("R12 blocked rd", r[0], 0);
      brk_pin[1] = 1'b0;
      tick(1);
      chk("R12 no late set", out_p, 0);
      wr(3'd4, 2'b11);
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      chk("R12 set after release", out_p, 4'hF);

      // R4 software trigger
      wr(3'd5, 2'b01);
      chk("R4 sw ch0 off", out_p, 0);
      rd(3'd5, r); chk("R4 swt reads 0", r, 0);
      tick(1); rd(3'd4, r); chk("R4 sticky ch0", r[1:0], 2'b01);
      wr(3'd4, 2'b11);
      wr(3'd0, ctrl(1, 1, 0, 0, 0, 0));
      tick(1);
      chk("R4 restored", out_p, 4'hF);
      wr(3'd5, 2'b10);
      chk("R4 sw ch1 ignores enable", out_p, 0);
      tick(1); rd(3'd4, r); chk("R4 sticky ch1", r[1:0], 2'b10);
      wr(3'd4, 2'b11);

      // R13 disabled channel ignores sources
      wr(3'd0, ctrl(1, 1, 0, 1, 0, 1));
      tick(1);
      wr(3'd1, DW'(3'b111));
      brk_pin = 2'b11; brk_int0 = 3'b111; brk_int1 = 3'b111;
      tick(2);
      chk("R13 outputs live", out_p, 4'hF);
      rd(3'd4, r); chk("R13 no sticky", r, 0);
      brk_pin = 0; brk_int0 = 0; brk_int1 = 0;

      // R3 masking and per-source polarity
      wr(3'd1, 0);
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      tick(1);
      brk_int0 = 3'b111;
      #0.5 chk("R3 masked", out_p, 4'hF);
      wr(3'd1, DW'(3'b010));
      chk("R3 src1 enabled", out_p, 0);
      brk_int0 = 3'b001;
      wr(3'd1, DW'({3'b011, 3'b011}));
      wr(3'd4, 2'b11);
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      chk("R3 inverted src0 idle", out_p, 4'hF);
      @(negedge clk); brk_int0 = 3'b000;
      #0.5 chk("R3 inverted src0 fault", out_p, 0);
      brk_int0 = 3'b001;
      wr(3'd4, 2'b11);
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      chk("R3 restored", out_p, 4'hF);
      @(negedge clk); brk_int0 = 3'b011;
      #0.5 chk("R3 src1 pol ignored", out_p, 0);
      brk_int0 = 3'b000;
      wr(3'd1, 0);
      wr(3'd4, 2'b11);
      wr(3'd0, ctrl(1, 1, 1, 1, 1, 1));
      wr(3'd2, DW'(3'b100));
      @(negedge clk); brk_int1 = 3'b100;
      #0.5 chk("R3 ch1 internal", out_p, 0);
      tick(1);
      rd(3'd4, r); chk("R11 ch1 internal sticky", r[1:0], 2'b10);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule